// File: doc/BRIEF.md
# System Control Port Register Block

This block sits on a byte-wide port bus of a legacy single-board computer and answers a small, sparse set of 8-bit ports. It holds the board's latched control bits: a reset request, a byte-order flag, a disk activity light, a 4-bit system control field and an I/O map mode bit. It also provides two general scratch bytes. It answers fixed identification and equipment bytes. Writes to two dedicated ports emit one-clock pulses that ask an external NVRAM to toggle one of its two password locks.

The host drives an address, a write or read strobe and write data. Writes take effect at the clock edge where the strobe is sampled. Read data is registered: it appears on `rd_data` one clock after the read strobe and holds until the next read. A read and a write in the same cycle return the value the port held before that write. A synchronous active-low reset clears every latched bit, both scratch bytes and the read register.

Top module: `sysport_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every control output, both scratch bytes and `rd_data` are cleared to zero.
- R2: A write to port 0x0092 sets `reset_req` from data bit 0 and `little_endian` from data bit 1. A read of 0x0092 returns 0x00.
- R3: Reads of ports 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these ports change no output and no readable value.
- R4: Reads of 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to 0x0808 sets `disk_light` from data bit 0.
- R6: A write to 0x0810 raises `lock1_toggle`, and a write to 0x0812 raises `lock2_toggle`. Each pulse is high in that cycle only. The two pulses are never high together.
- R7: A write to 0x081C stores data bits 3:0 into `sys_ctrl`. A read of 0x081C returns them, with bits 7:4 zero.
- R8: A write to 0x0850 stores data bit 0 into `io_map_mode`. A read of 0x0850 returns it in bit 0, with the other bits zero.
- R9: A read of any address not listed in R2 to R10 returns 0xFF. This includes 0x0808, 0x0812 and 0x0814. A write to such an address changes no output and no readable value.
- R10: Ports 0x0398 and 0x0399 are independent read/write scratch bytes.
- R11: `rd_data` updates one clock after `rd_en` is sampled and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | 16 | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| reset_req | output | 1 | Board reset request |
| little_endian | output | 1 | Byte-order mode flag |
| disk_light | output | 1 | Disk activity light |
| sys_ctrl | output | 4 | System control field |
| io_map_mode | output | 1 | I/O map mode bit |
| lock1_toggle | output | 1 | One-clock request to toggle NVRAM lock 1 |
| lock2_toggle | output | 1 | One-clock request to toggle NVRAM lock 2 |

## Verification
A latched bit that is wrong shows on its dedicated output one clock after the write that should have set it. Where the port can be read back, it also shows in `rd_data` one clock after the next read. A decode fault shows in one of three ways: as a read value other than the fixed constant or 0xFF, as a control output that moves after a write to a neighbouring port, or as a lock pulse in the wrong cycle. The bench keeps its own model of every latched value. It compares all outputs after every operation, so a fault is reported in the cycle where it first becomes visible.

// File: rtl/sysport_pkg.sv
// Package: port numbers, fixed read values and the decoded-select type
// shared by the system control port block.
package sysport_pkg;
    localparam int unsigned PORT_W    = 16;
    localparam int unsigned SYSC_W    = 4;
    localparam int unsigned SCR_N     = 2;

    localparam logic [PORT_W-1:0] A_SPECIAL  = 16'h0092;
    localparam logic [PORT_W-1:0] A_CPU_ID   = 16'h0800;
    localparam logic [PORT_W-1:0] A_FEATURE  = 16'h0802;
    localparam logic [PORT_W-1:0] A_STATUS   = 16'h0803;
    localparam logic [PORT_W-1:0] A_DISK     = 16'h0808;
    localparam logic [PORT_W-1:0] A_EQUIP    = 16'h080C;
    localparam logic [PORT_W-1:0] A_LOCK1    = 16'h0810;
    localparam logic [PORT_W-1:0] A_LOCK2    = 16'h0812;
    localparam logic [PORT_W-1:0] A_KEY      = 16'h0818;
    localparam logic [PORT_W-1:0] A_SYSC     = 16'h081C;
    localparam logic [PORT_W-1:0] A_CACHE    = 16'h0823;
    localparam logic [PORT_W-1:0] A_MAP      = 16'h0850;
    localparam logic [PORT_W-1:0] A_SCR_BASE = 16'h0398;

    localparam logic [7:0] V_CPU_ID  = 8'hEF;
    localparam logic [7:0] V_FEATURE = 8'hAD;
    localparam logic [7:0] V_STATUS  = 8'hE0;
    localparam logic [7:0] V_EQUIP   = 8'h3C;
    localparam logic [7:0] V_EXTFEAT = 8'h39;
    localparam logic [7:0] V_KEY     = 8'h00;
    localparam logic [7:0] V_CACHE   = 8'h03;
    localparam logic [7:0] V_SPECIAL = 8'h00;
    localparam logic [7:0] V_UNMAPPED = 8'hFF;

    // One bit per named port; scratch selects travel separately.
    typedef struct packed {
        logic special;
        logic cpu_id;
        logic feature;
        logic status;
        logic disk;
        logic equip;
        logic lock1;
        logic lock2;
        logic key;
        logic sysc;
        logic cache;
        logic map;
    } port_sel_t;
endpackage

// File: rtl/sysport_decode.sv
// Address decoder: compares the port address with each mapped port and
// produces one select per port. Assumes the address is stable while a
// strobe is high; at most one select is high for any address.
module sysport_decode
    import sysport_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_W,
    parameter int unsigned N_SCR  = SCR_N
) (
    input  logic [ADDR_W-1:0] port_addr,
    output port_sel_t         sel,
    output logic [N_SCR-1:0]  scr_sel
);
    // Compare against every named port.
    always_comb begin
        sel.special = (port_addr == ADDR_W'(A_SPECIAL));
        sel.cpu_id  = (port_addr == ADDR_W'(A_CPU_ID));
        sel.feature = (port_addr == ADDR_W'(A_FEATURE));
        sel.status  = (port_addr == ADDR_W'(A_STATUS));
        sel.disk    = (port_addr == ADDR_W'(A_DISK));
        sel.equip   = (port_addr == ADDR_W'(A_EQUIP));
        sel.lock1   = (port_addr == ADDR_W'(A_LOCK1));
        sel.lock2   = (port_addr == ADDR_W'(A_LOCK2));
        sel.key     = (port_addr == ADDR_W'(A_KEY));
        sel.sysc    = (port_addr == ADDR_W'(A_SYSC));
        sel.cache   = (port_addr == ADDR_W'(A_CACHE));
        sel.map     = (port_addr == ADDR_W'(A_MAP));
    end

    // One comparator per scratch byte, consecutive from the base port.
    for (genvar g = 0; g < N_SCR; g++) begin : g_scr_dec
        assign scr_sel[g] = (port_addr == ADDR_W'(A_SCR_BASE + g));
    end
endmodule

// File: rtl/sysport_regs.sv
// Latched control state and lock pulses. Writes take effect on the clock
// edge where wr_en is sampled; lock pulses are combinational from the
// strobe and last exactly as long as the write cycle.
module sysport_regs
    import sysport_pkg::*;
#(
    parameter int unsigned CTRL_W = SYSC_W,
    parameter int unsigned N_SCR  = SCR_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  port_sel_t            sel,
    input  logic [N_SCR-1:0]     scr_sel,
    output logic                 reset_req,
    output logic                 little_endian,
    output logic                 disk_light,
    output logic [CTRL_W-1:0]    sys_ctrl,
    output logic                 io_map_mode,
    output logic [N_SCR*8-1:0]   scr_q,
    output logic                 lock1_toggle,
    output logic                 lock2_toggle
);
    // Special port: reset request and byte order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req     <= 1'b0;
            little_endian <= 1'b0;
        end else if (wr_en && sel.special) begin
            reset_req     <= wr_data[0];
            little_endian <= wr_data[1];
        end
    end

    // Disk light, system control field and map mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disk_light  <= 1'b0;
            sys_ctrl    <= '0;
            io_map_mode <= 1'b0;
        end else if (wr_en) begin
            if (sel.disk) disk_light  <= wr_data[0];
            if (sel.sysc) sys_ctrl    <= wr_data[CTRL_W-1:0];
            if (sel.map)  io_map_mode <= wr_data[0];
        end
    end

    // Scratch bytes, one register per port.
    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n)                  scr_q[g*8 +: 8] <= 8'h00;
            else if (wr_en && scr_sel[g]) scr_q[g*8 +: 8] <= wr_data;
        end
    end

    // Lock toggle requests follow the accepted write.
    assign lock1_toggle = wr_en && sel.lock1;
    assign lock2_toggle = wr_en && sel.lock2;

    // R2
    special_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.special) |=> (reset_req == $past(wr_data[0]) &&
                                    little_endian == $past(wr_data[1])));
    // R7
    sysc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel.sysc) |=> $stable(sys_ctrl));
    // R6
    lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock1_toggle, lock2_toggle}));
endmodule

// File: rtl/sysport_rdmux.sv
// Read path: selects the addressed byte and registers it when rd_en is
// sampled. Unmapped addresses give all ones. Holds between reads.
module sysport_rdmux
    import sysport_pkg::*;
#(
    parameter int unsigned CTRL_W = SYSC_W,
    parameter int unsigned N_SCR  = SCR_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  port_sel_t          sel,
    input  logic [N_SCR-1:0]   scr_sel,
    input  logic [CTRL_W-1:0]  sys_ctrl,
    input  logic               io_map_mode,
    input  logic [N_SCR*8-1:0] scr_q,
    output logic [7:0]         rd_data
);
    logic [7:0] rd_next;
    logic       any_sel;

    // Pick the byte for the addressed port.
    always_comb begin
        rd_next = V_UNMAPPED;
        if (sel.special) rd_next = V_SPECIAL;
        if (sel.cpu_id)  rd_next = V_CPU_ID;
        if (sel.feature) rd_next = V_FEATURE;
        if (sel.status)  rd_next = V_STATUS;
        if (sel.equip)   rd_next = V_EQUIP;
        if (sel.lock1)   rd_next = V_EXTFEAT;
        if (sel.key)     rd_next = V_KEY;
        if (sel.cache)   rd_next = V_CACHE;
        if (sel.sysc)    rd_next = 8'(sys_ctrl);
        if (sel.map)     rd_next = {7'b0, io_map_mode};
        for (int i = 0; i < N_SCR; i++)
            if (scr_sel[i]) rd_next = scr_q[i*8 +: 8];
    end

    // Flag for a readable port (the disk and lock-2 ports read as unmapped).
    assign any_sel = sel.special | sel.cpu_id | sel.feature | sel.status |
                     sel.equip | sel.lock1 | sel.key | sel.cache |
                     sel.sysc | sel.map | (|scr_sel);

    // Read register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R9
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_sel) |=> (rd_data == 8'hFF));
endmodule

// File: rtl/sysport_ctrl.sv
// Top: system control port register block. Connects the decoder, the
// control registers and the read path. Assumes single-byte accesses on a
// synchronous port bus; synchronous active-low reset.
module sysport_ctrl
    import sysport_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_W,
    parameter int unsigned CTRL_W = SYSC_W,
    parameter int unsigned N_SCR  = SCR_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              reset_req,
    output logic              little_endian,
    output logic              disk_light,
    output logic [CTRL_W-1:0] sys_ctrl,
    output logic              io_map_mode,
    output logic              lock1_toggle,
    output logic              lock2_toggle
);
    port_sel_t          sel;
    logic [N_SCR-1:0]   scr_sel;
    logic [N_SCR*8-1:0] scr_q;

    sysport_decode #(.ADDR_W(ADDR_W), .N_SCR(N_SCR)) u_decode (
        .port_addr (port_addr),
        .sel       (sel),
        .scr_sel   (scr_sel)
    );

    sysport_regs #(.CTRL_W(CTRL_W), .N_SCR(N_SCR)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .sel           (sel),
        .scr_sel       (scr_sel),
        .reset_req     (reset_req),
        .little_endian (little_endian),
        .disk_light    (disk_light),
        .sys_ctrl      (sys_ctrl),
        .io_map_mode   (io_map_mode),
        .scr_q         (scr_q),
        .lock1_toggle  (lock1_toggle),
        .lock2_toggle  (lock2_toggle)
    );

    sysport_rdmux #(.CTRL_W(CTRL_W), .N_SCR(N_SCR)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .sel         (sel),
        .scr_sel     (scr_sel),
        .sys_ctrl    (sys_ctrl),
        .io_map_mode (io_map_mode),
        .scr_q       (scr_q),
        .rd_data     (rd_data)
    );

    // R5
    disk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && port_addr == ADDR_W'(A_DISK)) |=> $stable(disk_light));
endmodule

// File: tb/sysport_ctrl_bench.sv
// Bench: directed corner cases, then seeded random reads and writes
// over the mapped ports and their neighbours, checked against a model.
module sysport_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        reset_req, little_endian, disk_light, io_map_mode;
    logic        lock1_toggle, lock2_toggle;
    logic [3:0]  sys_ctrl;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // Model state.
    logic       m_rst, m_le, m_disk, m_map;
    logic [3:0] m_sysc;
    logic [7:0] m_scr0, m_scr1, m_rd;

    always #2.5 clk = ~clk;

    sysport_ctrl u_sysport_ctrl (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .reset_req(reset_req), .little_endian(little_endian),
        .disk_light(disk_light), .sys_ctrl(sys_ctrl),
        .io_map_mode(io_map_mode), .lock1_toggle(lock1_toggle),
        .lock2_toggle(lock2_toggle)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected read value from the model state.
    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            16'h0092: return 8'h00;
            16'h0800: return 8'hEF;
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h0823: return 8'h03;
            16'h081C: return {4'b0, m_sysc};
            16'h0850: return {7'b0, m_map};
            16'h0398: return m_scr0;
            16'h0399: return m_scr1;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic string read_tag(input logic [15:0] a);
        case (a)
            16'h0092: return "R2 read special";
            16'h0800, 16'h0802, 16'h0803: return "R3 id read";
            16'h080C, 16'h0810, 16'h0818, 16'h0823: return "R4 equip read";
            16'h081C: return "R7 sysctrl read";
            16'h0850: return "R8 map read";
            16'h0398, 16'h0399: return "R10 scratch read";
            default:  return "R9 unmapped read";
        endcase
    endfunction

    function automatic logic [15:0] pick_addr(input int unsigned k);
        case (k % 20)
            0: return 16'h0092;  1: return 16'h0800;  2: return 16'h0802;
            3: return 16'h0803;  4: return 16'h0808;  5: return 16'h080C;
            6: return 16'h0810;  7: return 16'h0812;  8: return 16'h0814;
            9: return 16'h0818; 10: return 16'h081C; 11: return 16'h0823;
           12: return 16'h0850; 13: return 16'h0398; 14: return 16'h0399;
           15: return 16'h0801; 16: return 16'h0851; 17: return 16'h0397;
           18: return 16'h039A; default: return 16'(k >> 5);
        endcase
    endfunction

    task automatic model_reset();
        m_rst = 0; m_le = 0; m_disk = 0; m_map = 0; m_sysc = 0;
        m_scr0 = 0; m_scr1 = 0; m_rd = 0;
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " reset_req (R2)"}, 32'(reset_req), 32'(m_rst));
        check({tag, " little_endian (R2)"}, 32'(little_endian), 32'(m_le));
        check({tag, " disk_light (R5)"}, 32'(disk_light), 32'(m_disk));
        check({tag, " sys_ctrl (R7)"}, 32'(sys_ctrl), 32'(m_sysc));
        check({tag, " io_map_mode (R8)"}, 32'(io_map_mode), 32'(m_map));
    endtask

    // One bus cycle, starting and ending at a falling edge.
    task automatic bus_op(input bit do_wr, input bit do_rd,
                          input logic [15:0] a, input logic [7:0] d);
        logic [7:0] rexp;
        port_addr = a; wr_en = do_wr; rd_en = do_rd; wr_data = d;
        #1;
        check("R6 lock1 pulse", 32'(lock1_toggle), 32'(do_wr && a == 16'h0810));
        check("R6 lock2 pulse", 32'(lock2_toggle), 32'(do_wr && a == 16'h0812));
        rexp = exp_read(a);
        @(posedge clk);
        if (do_rd) m_rd = rexp;
        if (do_wr) begin
            case (a)
                16'h0092: begin m_rst = d[0]; m_le = d[1]; end
                16'h0808: m_disk = d[0];
                16'h081C: m_sysc = d[3:0];
                16'h0850: m_map = d[0];
                16'h0398: m_scr0 = d;
                16'h0399: m_scr1 = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        #1;
        check("R6 lock pulses end", 32'({lock1_toggle, lock2_toggle}), 32'd0);
        if (do_rd) check(read_tag(a), 32'(rd_data), 32'(m_rd));
        else       check("R11 rd_data holds", 32'(rd_data), 32'(m_rd));
        check_outputs("state");
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Dirty everything, then reset again: R1.
        bus_op(1, 0, 16'h0092, 8'h03);
        bus_op(1, 0, 16'h081C, 8'hFF);
        bus_op(1, 0, 16'h0398, 8'h5A);
        bus_op(0, 1, 16'h0800, 8'h00);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        #1;
        check("R1 rd_data after reset", 32'(rd_data), 32'd0);
        check_outputs("R1 after reset");
        bus_op(0, 1, 16'h0398, 8'h00);

        // Directed corners.
        bus_op(1, 0, 16'h0092, 8'hFE);    // R2 bit0 low, bit1 high
        bus_op(0, 1, 16'h0092, 8'h00);
        bus_op(1, 0, 16'h0800, 8'h12);    // R3 write ignored
        bus_op(0, 1, 16'h0800, 8'h00);
        bus_op(1, 0, 16'h0814, 8'hFF);    // R9 write ignored
        bus_op(0, 1, 16'h0814, 8'h00);
        bus_op(1, 0, 16'h0808, 8'h01);    // R5
        bus_op(0, 1, 16'h0808, 8'h00);    // R9 reads as unmapped
        bus_op(1, 0, 16'h081C, 8'hA7);    // R7 upper bits dropped
        bus_op(0, 1, 16'h081C, 8'h00);
        bus_op(1, 0, 16'h0850, 8'hFE);    // R8 bit0 only
        bus_op(1, 0, 16'h0850, 8'h01);
        bus_op(0, 1, 16'h0850, 8'h00);
        bus_op(1, 0, 16'h0399, 8'hC3);    // R10 independence
        bus_op(0, 1, 16'h0398, 8'h00);
        bus_op(0, 1, 16'h0399, 8'h00);
        bus_op(1, 1, 16'h0399, 8'h11);    // read sees the old byte
        bus_op(0, 1, 16'h0399, 8'h00);
        bus_op(1, 0, 16'h0810, 8'h00);    // R6
        bus_op(1, 0, 16'h0812, 8'h00);
        bus_op(0, 1, 16'h0812, 8'h00);
        bus_op(0, 1, 16'h080C, 8'h00);    // R4
        bus_op(0, 1, 16'h0823, 8'h00);

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            int unsigned kind = $urandom % 3;
            bus_op(kind != 1, kind != 0, pick_addr(r), 8'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule